// File: doc/BRIEF.md
# Frequency Select and Strap Latch

This block chooses the operating frequency code and the divider pair that a clock synthesiser runs from. At power-up it takes one snapshot of five frequency-select straps and a current-multiplier strap. The snapshot is taken in the first clock cycle in which the active-low power-good input is seen low. After that, the straps and the power-good input have no further effect. The captured values remain visible on dedicated outputs.

A software override level picks the active 5-bit code: either the latched straps or a software code. A programmable mode adds a divider pair N (8 bits) and M (7 bits) that sets the CPU rate as G·(N+3)/(M+3). The override still decides which code supplies the gear constant and the output ratios.

A one-cycle write strobe on either N or M loads a new pair. A field whose strobe is idle keeps its current value. A pair that does not give N+3 > M+3 is refused: the old pair stays and an error flag is set. Any change of the active code or of the active pair gives a single-cycle change pulse for the downstream watchdog and reset logic. The block also selects the output-current multiplier, from the strap or from a software field.

Top module: `fsel_ctrl`

## Requirements
- R1: The straps are captured at the first rising edge at which `pg_n` is 0, and `strap_valid` is then 1. After that edge, changes on `pg_n`, `strap_fs` and `strap_mult` leave `latched_fs` and `latched_mult` unchanged.
- R2: Before capture, `latched_fs`, `latched_mult` and `strap_valid` are 0. After capture they read back the sampled strap values.
- R3: `act_code` follows `sw_code` when `ovr_sel` is 1 and `latched_fs` when `ovr_sel` is 0. This holds in both modes, and `act_code` updates at the first rising edge after the selected source changes.
- R4: With `prog_en` at 1, `prog_mode` is 1 and `act_n`/`act_m` carry the loaded pair. With `prog_en` at 0, `prog_mode` is 0 and `act_n`/`act_m` are 0.
- R5: A strobe on `n_wr` or on `m_wr` loads a new pair. A field whose strobe is idle keeps its stored value, and strobes in the same cycle are applied together. The loaded pair reaches `act_n`/`act_m` at the second rising edge after the write.
- R6: A write that would give N+3 ≤ M+3 is refused. The stored pair is unchanged and `nm_err` becomes 1 at the first edge after the write. The next accepted write clears `nm_err`.
- R7: `freq_chg` is 1 for exactly one cycle after any edge that changes `act_code`, `act_n` or `act_m`. It also pulses on an accepted load while `prog_en` is 1, even if the values do not change. Several changes at one edge give one pulse.
- R8: `iref_mult` is 4 when `mult_ovr` is 0 and the latched multiplier strap is 0. It is 6 when `mult_ovr` is 0 and that strap is 1. When `mult_ovr` is 1 it is 4 plus the 2-bit `mult_sw` field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_n | input | 1 | Active-low power-good strobe for strap capture |
| strap_fs | input | 5 | Frequency-select straps |
| strap_mult | input | 1 | Current-multiplier strap |
| ovr_sel | input | 1 | 0: strap code, 1: software code |
| sw_code | input | 5 | Software frequency-select code |
| prog_en | input | 1 | Programmable divider mode enable |
| n_wr | input | 1 | Write strobe for N |
| n_val | input | 8 | N value written |
| m_wr | input | 1 | Write strobe for M |
| m_val | input | 7 | M value written |
| mult_ovr | input | 1 | 0: strap multiplier, 1: software field |
| mult_sw | input | 2 | Software multiplier field (4 + value) |
| latched_fs | output | 5 | Captured frequency straps |
| latched_mult | output | 1 | Captured multiplier strap |
| strap_valid | output | 1 | Straps have been captured |
| act_code | output | 5 | Active frequency-select code |
| act_n | output | 8 | Active N (0 outside programmable mode) |
| act_m | output | 7 | Active M (0 outside programmable mode) |
| prog_mode | output | 1 | Programmable mode in effect |
| nm_err | output | 1 | Last write refused |
| freq_chg | output | 1 | One-cycle frequency-change pulse |
| iref_mult | output | 3 | Output-current multiplier, 4 to 7 |

## Verification
A code change and a divider load can land on the same edge, and the bench makes this happen on purpose. It writes N, then flips `ovr_sel` one cycle later, so that the code change and the new N both register at the second edge after the write. At that edge `act_code` and `act_n` must both take their new values. `freq_chg` must be high for only that one cycle and low on the next, which shows the two causes merge into a single pulse.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int MUL_W  = 3;

  // N+3 must exceed M+3
  function automatic logic pair_ok(input logic [N_W-1:0] n, input logic [M_W-1:0] m);
    logic [N_W:0] nn;
    logic [N_W:0] mm;
    nn = {1'b0, n} + (N_W+1)'(3);
    mm = (N_W+1)'(m) + (N_W+1)'(3);
    return nn > mm;
  endfunction

  function automatic logic [MUL_W-1:0] mult_from_strap(input logic s);
    return s ? MUL_W'(6) : MUL_W'(4);
  endfunction

  function automatic logic [MUL_W-1:0] mult_from_sw(input logic [1:0] f);
    return MUL_W'(4) + MUL_W'(f);
  endfunction
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
  parameter int CODE_W = fsel_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_n,
  input  logic [CODE_W-1:0] strap_fs,
  input  logic              strap_mult,
  output logic [CODE_W-1:0] latched_fs,
  output logic              latched_mult,
  output logic              strap_valid
);
  logic capture_evt;
  assign capture_evt = !strap_valid && !pg_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_fs   <= '0;
      latched_mult <= 1'b0;
      strap_valid  <= 1'b0;
    end else if (capture_evt) begin
      latched_fs   <= strap_fs;
      latched_mult <= strap_mult;
      strap_valid  <= 1'b1;
    end
  end

  // R1: once captured, the snapshot never moves
  a_r1_hold_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strap_valid |=> (strap_valid && $stable(latched_fs) && $stable(latched_mult)));

  // R1: capture happens on the first low power-good cycle
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> strap_valid);
endmodule

// File: rtl/fsel_nm_reg.sv
module fsel_nm_reg #(
  parameter int N_W = fsel_pkg::N_W,
  parameter int M_W = fsel_pkg::M_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           n_wr,
  input  logic [N_W-1:0] n_val,
  input  logic           m_wr,
  input  logic [M_W-1:0] m_val,
  output logic [N_W-1:0] cur_n,
  output logic [M_W-1:0] cur_m,
  output logic           nm_load,
  output logic           nm_err
);
  logic [N_W-1:0] cand_n;
  logic [M_W-1:0] cand_m;
  logic           any_wr;
  logic           cand_ok;

  assign cand_n  = n_wr ? n_val : cur_n;
  assign cand_m  = m_wr ? m_val : cur_m;
  assign any_wr  = n_wr || m_wr;
  assign cand_ok = fsel_pkg::pair_ok(cand_n, cand_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n   <= '0;
      cur_m   <= '0;
      nm_load <= 1'b0;
      nm_err  <= 1'b0;
    end else begin
      nm_load <= any_wr && cand_ok;
      if (any_wr) begin
        if (cand_ok) begin
          cur_n  <= cand_n;
          cur_m  <= cand_m;
          nm_err <= 1'b0;
        end else begin
          nm_err <= 1'b1;
        end
      end
    end
  end

  // R6: a refused write keeps the pair and flags the error
  a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !cand_ok) |=> ($stable(cur_n) && $stable(cur_m) && nm_err && !nm_load));

  // R6: every loaded pair satisfies N > M
  a_r6_loaded_valid: assert property (@(posedge clk) disable iff (!rst_n)
    nm_load |-> ({1'b0, cur_n} > (N_W+1)'(cur_m)));

  // R5: an accepted write produces a load event
  a_r5_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && cand_ok) |=> (nm_load && !nm_err));
endmodule

// File: rtl/fsel_select.sv
module fsel_select #(
  parameter int CODE_W = fsel_pkg::CODE_W,
  parameter int N_W    = fsel_pkg::N_W,
  parameter int M_W    = fsel_pkg::M_W,
  parameter int MUL_W  = fsel_pkg::MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] latched_fs,
  input  logic              latched_mult,
  input  logic              ovr_sel,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              prog_en,
  input  logic [N_W-1:0]    cur_n,
  input  logic [M_W-1:0]    cur_m,
  input  logic              nm_load,
  input  logic              mult_ovr,
  input  logic [1:0]        mult_sw,
  output logic [CODE_W-1:0] act_code,
  output logic [N_W-1:0]    act_n,
  output logic [M_W-1:0]    act_m,
  output logic              prog_mode,
  output logic [MUL_W-1:0]  iref_mult,
  output logic              freq_chg
);
  logic [CODE_W-1:0] nxt_code;
  logic [N_W-1:0]    nxt_n;
  logic [M_W-1:0]    nxt_m;
  logic [MUL_W-1:0]  nxt_mult;
  logic              change_evt;

  assign nxt_code = ovr_sel ? sw_code : latched_fs;
  assign nxt_n    = prog_en ? cur_n : '0;
  assign nxt_m    = prog_en ? cur_m : '0;
  assign nxt_mult = mult_ovr ? fsel_pkg::mult_from_sw(mult_sw)
                             : fsel_pkg::mult_from_strap(latched_mult);
  assign change_evt = (nxt_code != act_code) || (nxt_n != act_n) ||
                      (nxt_m != act_m) || (prog_en && nm_load);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code  <= '0;
      act_n     <= '0;
      act_m     <= '0;
      prog_mode <= 1'b0;
      iref_mult <= MUL_W'(4);
      freq_chg  <= 1'b0;
    end else begin
      act_code  <= nxt_code;
      act_n     <= nxt_n;
      act_m     <= nxt_m;
      prog_mode <= prog_en;
      iref_mult <= nxt_mult;
      freq_chg  <= change_evt;
    end
  end

  // R7: any visible change of code or pair carries a pulse
  a_r7_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_code != $past(act_code)) || (act_n != $past(act_n)) || (act_m != $past(act_m)))
      |-> freq_chg);

  // R4: outside programmable mode the pair reads zero
  a_r4_zero_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |-> (act_n == '0 && act_m == '0));

  // R8: multiplier stays within 4..7
  a_r8_mult_range: assert property (@(posedge clk) disable iff (!rst_n)
    (iref_mult >= MUL_W'(4)) && (iref_mult <= MUL_W'(7)));
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl #(
  parameter int CODE_W = fsel_pkg::CODE_W,
  parameter int N_W    = fsel_pkg::N_W,
  parameter int M_W    = fsel_pkg::M_W,
  parameter int MUL_W  = fsel_pkg::MUL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_n,
  input  logic [CODE_W-1:0] strap_fs,
  input  logic              strap_mult,
  input  logic              ovr_sel,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              prog_en,
  input  logic              n_wr,
  input  logic [N_W-1:0]    n_val,
  input  logic              m_wr,
  input  logic [M_W-1:0]    m_val,
  input  logic              mult_ovr,
  input  logic [1:0]        mult_sw,
  output logic [CODE_W-1:0] latched_fs,
  output logic              latched_mult,
  output logic              strap_valid,
  output logic [CODE_W-1:0] act_code,
  output logic [N_W-1:0]    act_n,
  output logic [M_W-1:0]    act_m,
  output logic              prog_mode,
  output logic              nm_err,
  output logic              freq_chg,
  output logic [MUL_W-1:0]  iref_mult
);
  logic [N_W-1:0] cur_n;
  logic [M_W-1:0] cur_m;
  logic           nm_load;

  fsel_strap_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .strap_fs(strap_fs),
    .strap_mult(strap_mult), .latched_fs(latched_fs),
    .latched_mult(latched_mult), .strap_valid(strap_valid)
  );

  fsel_nm_reg #(.N_W(N_W), .M_W(M_W)) u_nm (
    .clk(clk), .rst_n(rst_n), .n_wr(n_wr), .n_val(n_val),
    .m_wr(m_wr), .m_val(m_val), .cur_n(cur_n), .cur_m(cur_m),
    .nm_load(nm_load), .nm_err(nm_err)
  );

  fsel_select #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W), .MUL_W(MUL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .latched_fs(latched_fs),
    .latched_mult(latched_mult), .ovr_sel(ovr_sel), .sw_code(sw_code),
    .prog_en(prog_en), .cur_n(cur_n), .cur_m(cur_m), .nm_load(nm_load),
    .mult_ovr(mult_ovr), .mult_sw(mult_sw), .act_code(act_code),
    .act_n(act_n), .act_m(act_m), .prog_mode(prog_mode),
    .iref_mult(iref_mult), .freq_chg(freq_chg)
  );

  // R3: code source follows the override one edge later
  a_r3_code_source: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (act_code == ($past(ovr_sel) ? $past(sw_code) : $past(latched_fs))));
endmodule

// File: tb/fsel_ctrl_test.sv
module fsel_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pg_n = 1'b1;
  logic [4:0] strap_fs = 5'd0;
  logic       strap_mult = 1'b0;
  logic       ovr_sel = 1'b0;
  logic [4:0] sw_code = 5'd0;
  logic       prog_en = 1'b0;
  logic       n_wr = 1'b0;
  logic [7:0] n_val = 8'd0;
  logic       m_wr = 1'b0;
  logic [6:0] m_val = 7'd0;
  logic       mult_ovr = 1'b0;
  logic [1:0] mult_sw = 2'd0;
  logic [4:0] latched_fs;
  logic       latched_mult;
  logic       strap_valid;
  logic [4:0] act_code;
  logic [7:0] act_n;
  logic [6:0] act_m;
  logic       prog_mode;
  logic       nm_err;
  logic       freq_chg;
  logic [2:0] iref_mult;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsel_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .strap_fs(strap_fs),
    .strap_mult(strap_mult), .ovr_sel(ovr_sel), .sw_code(sw_code),
    .prog_en(prog_en), .n_wr(n_wr), .n_val(n_val), .m_wr(m_wr),
    .m_val(m_val), .mult_ovr(mult_ovr), .mult_sw(mult_sw),
    .latched_fs(latched_fs), .latched_mult(latched_mult),
    .strap_valid(strap_valid), .act_code(act_code), .act_n(act_n),
    .act_m(act_m), .prog_mode(prog_mode), .nm_err(nm_err),
    .freq_chg(freq_chg), .iref_mult(iref_mult)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R2 latched_fs at reset", latched_fs, 0);
    check("R2 strap_valid at reset", strap_valid, 0);
    check("R4 prog_mode at reset", prog_mode, 0);
    check("R7 freq_chg at reset", freq_chg, 0);
  endtask

  task automatic t_strap;
    strap_fs = 5'd19; strap_mult = 1'b1; pg_n = 1'b0;
    step(1);
    check("R1 capture valid", strap_valid, 1);
    check("R2 latched_fs value", latched_fs, 19);
    check("R2 latched_mult value", latched_mult, 1);
    pg_n = 1'b1; strap_fs = 5'd7; strap_mult = 1'b0;
    step(1);
    check("R3 code from straps", act_code, 19);
    check("R7 pulse on strap code", freq_chg, 1);
    check("R8 strap mult 1 -> 6", iref_mult, 6);
    pg_n = 1'b0; step(1); pg_n = 1'b1; step(2);
    check("R1 later straps ignored", latched_fs, 19);
    check("R1 later mult ignored", latched_mult, 1);
    check("R7 no pulse when idle", freq_chg, 0);
  endtask

  task automatic t_override;
    sw_code = 5'd5; ovr_sel = 1'b1;
    step(1);
    check("R3 override selects sw code", act_code, 5);
    check("R7 pulse on override", freq_chg, 1);
    step(1);
    check("R7 pulse single cycle", freq_chg, 0);
    ovr_sel = 1'b0;
    step(1);
    check("R3 back to strap code", act_code, 19);
  endtask

  task automatic t_prog;
    prog_en = 1'b1;
    n_wr = 1'b1; n_val = 8'd127; m_wr = 1'b1; m_val = 7'd45;
    step(1);
    n_wr = 1'b0; m_wr = 1'b0;
    check("R6 nm_err clear on good write", nm_err, 0);
    step(1);
    check("R4 prog_mode", prog_mode, 1);
    check("R5 act_n loaded", act_n, 127);
    check("R5 act_m loaded", act_m, 45);
    check("R7 pulse on load", freq_chg, 1);
    // N only: M keeps 45
    n_wr = 1'b1; n_val = 8'd200;
    step(1); n_wr = 1'b0; step(1);
    check("R5 N-only write", act_n, 200);
    check("R5 M kept", act_m, 45);
    // same value rewrite still pulses
    m_wr = 1'b1; m_val = 7'd45;
    step(1); m_wr = 1'b0; step(1);
    check("R7 pulse on reload", freq_chg, 1);
    step(1);
    check("R7 reload pulse ends", freq_chg, 0);
  endtask

  task automatic t_invalid;
    m_wr = 1'b1; m_val = 7'd120;   // N=200 > 120 ok
    step(1); m_wr = 1'b0; step(1);
    check("R5 M-only write", act_m, 120);
    n_wr = 1'b1; n_val = 8'd120;   // equal -> refused
    step(1); n_wr = 1'b0;
    check("R6 error on N==M", nm_err, 1);
    step(1);
    check("R6 N kept", act_n, 200);
    check("R6 no pulse on refusal", freq_chg, 0);
    n_wr = 1'b1; n_val = 8'd121;
    step(1); n_wr = 1'b0;
    check("R6 error cleared", nm_err, 0);
    step(1);
    check("R6 boundary N=M+1 accepted", act_n, 121);
  endtask

  task automatic t_same_edge;
    n_wr = 1'b1; n_val = 8'd150;
    step(1);
    n_wr = 1'b0; sw_code = 5'd9; ovr_sel = 1'b1;
    step(1);
    check("R3 code at joint edge", act_code, 9);
    check("R5 N at joint edge", act_n, 150);
    check("R7 joint pulse", freq_chg, 1);
    step(1);
    check("R7 joint pulse one cycle", freq_chg, 0);
    prog_en = 1'b0;
    step(1);
    check("R4 pair zero when off", act_n + act_m, 0);
    check("R4 prog_mode off", prog_mode, 0);
    check("R3 code kept in fixed mode", act_code, 9);
  endtask

  task automatic t_mult;
    mult_ovr = 1'b1; mult_sw = 2'd3;
    step(1);
    check("R8 sw field 3 -> 7", iref_mult, 7);
    mult_sw = 2'd1;
    step(1);
    check("R8 sw field 1 -> 5", iref_mult, 5);
    mult_ovr = 1'b0;
    step(1);
    check("R8 back to strap", iref_mult, 6);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_strap();
    t_override();
    t_prog();
    t_invalid();
    t_same_edge();
    t_mult();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule